// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock

This block is the hazard control for a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory access and write-back. Operands are read in decode and results are written in write-back, and every instruction passes through all five stages. Read-after-write dependences are therefore the only hazards. Write-after-read and write-after-write cannot arise.

The block receives the decoded fields of the instruction in decode: two source register numbers, a destination, a register-write enable, a memory-write enable and a load flag. It keeps its own copies of these control fields for the execute, memory and write-back pipeline registers. From these copies it drives the select lines of the two ALU operand multiplexers, so that a result still in flight is bypassed to the instruction in execute.

When a load sits in execute and the instruction in decode reads the loaded register, the block raises `stall` for one cycle. During that cycle the surrounding pipeline holds the PC and the fetch/decode register. The block then loads an empty slot, flagged as a bubble, into its execute register. The register file is assumed to write before it reads within a cycle, so a producer three instructions ahead needs no bypass.

Top module: `bypass_interlock`

## Requirements
- R1: After synchronous reset, both operand selects are 2'b00, `stall` is 0, and the execute slot holds no operation: `ex_reg_we`, `ex_mem_we`, `ex_is_load` and `ex_bubble` are all 0.
- R2: When the instruction in execute reads a register that the instruction one stage ahead writes (register-write enable 1, destination not 0), that operand's select is 2'b10, the ALU-result path. An adjacent ALU producer and consumer cause no stall.
- R3: When the match is with the instruction two stages ahead (the memory/write-back register), the select is 2'b01, the write-back path.
- R4: When both later stages write the register an operand reads, the younger one wins and the select is 2'b10.
- R5: An operand with no matching producer selects 2'b00, the register file. The two operands are decided independently of each other.
- R6: A destination of register 0 never causes a bypass and never causes a stall.
- R7: `stall` is 1 exactly when the execute slot holds a load with a nonzero destination that either decode source reads. For one load-use pair it is high for exactly one cycle.
- R8: In the cycle after a stall, the execute slot is a bubble: `ex_bubble` is 1 and `ex_reg_we`, `ex_mem_we` and `ex_is_load` are 0. The held decode instruction enters execute in the following cycle.
- R9: A load with one unrelated instruction between it and its consumer causes no stall. It is bypassed to the consumer with select 2'b01.
- R10: A producer whose register-write enable is 0 is never bypassed and never stalls a consumer, whatever its destination field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_rd | input | 5 | Destination register of the decode instruction |
| id_reg_we | input | 1 | Decode instruction writes a register |
| id_mem_we | input | 1 | Decode instruction writes memory |
| id_is_load | input | 1 | Decode instruction is a load |
| fwd_a_sel | output | 2 | First ALU operand select: 00 register file, 01 write-back, 10 ALU result |
| fwd_b_sel | output | 2 | Second ALU operand select, same encoding |
| stall | output | 1 | Hold PC and fetch/decode register; bubble enters execute at this edge |
| ex_rd | output | 5 | Destination of the execute slot |
| ex_reg_we | output | 1 | Register-write enable of the execute slot |
| ex_mem_we | output | 1 | Memory-write enable of the execute slot |
| ex_is_load | output | 1 | Execute slot is a load |
| ex_bubble | output | 1 | Execute slot is an inserted bubble |

## Verification
A stall for the decode instruction and a bypass select for the instruction in execute can fall in the same cycle. The bench provokes this with an ALU write to r3, then a load whose address comes from r3, then a consumer of the loaded register. In the consumer's first decode cycle, `stall` must be 1 and the load's own first-operand select must read 2'b10 at the same time. The following cycles must show the bubble, then the loaded value bypassed on 2'b01.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int REG_AW  = 5;
    localparam int NUM_SRC = 2;
    localparam int SEL_W   = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [SEL_W-1:0] {
        OPSEL_RF  = 2'b00,
        OPSEL_WB  = 2'b01,
        OPSEL_ALU = 2'b10
    } opsel_e;

    // full control slot held in the execute register
    typedef struct packed {
        reg_idx_t rs1;
        reg_idx_t rs2;
        reg_idx_t rd;
        logic     reg_we;
        logic     mem_we;
        logic     is_load;
        logic     bubble;
    } slot_t;

    // destination view kept for the two later stages
    typedef struct packed {
        reg_idx_t rd;
        logic     reg_we;
        logic     is_load;
    } dst_t;

    localparam slot_t SLOT_EMPTY = '0;
    localparam dst_t  DST_EMPTY  = '0;

    function automatic slot_t make_bubble();
        slot_t s;
        s        = SLOT_EMPTY;
        s.bubble = 1'b1;
        return s;
    endfunction

    function automatic dst_t to_dst(slot_t s);
        dst_t d;
        d.rd      = s.rd;
        d.reg_we  = s.reg_we;
        d.is_load = s.is_load;
        return d;
    endfunction

    // a producer counts only if it writes and its destination is not r0
    function automatic logic produces(dst_t d, reg_idx_t r);
        return d.reg_we && (d.rd != '0) && (d.rd == r);
    endfunction

endpackage

// File: rtl/bypass_stage_regs.sv
module bypass_stage_regs
    import bypass_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  insert_bubble,
    input  slot_t id_slot,
    output slot_t idex_q,
    output dst_t  exmem_q,
    output dst_t  memwb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idex_q  <= SLOT_EMPTY;
            exmem_q <= DST_EMPTY;
            memwb_q <= DST_EMPTY;
        end else begin
            memwb_q <= exmem_q;
            exmem_q <= to_dst(idex_q);
            if (insert_bubble) begin
                idex_q <= make_bubble();
            end else begin
                idex_q <= id_slot;
            end
        end
    end

    // R8: a stall edge leaves a harmless bubble in execute
    a_r8_bubble_clears_writes: assert property (@(posedge clk) disable iff (rst)
        insert_bubble |=> (idex_q.bubble && !idex_q.reg_we && !idex_q.mem_we && !idex_q.is_load));

    // R8: the bubble travels on as a slot that writes nothing
    a_r8_bubble_flows_down: assert property (@(posedge clk) disable iff (rst)
        idex_q.bubble |=> (!exmem_q.reg_we && !exmem_q.is_load));

endmodule

// File: rtl/bypass_operand_sel.sv
module bypass_operand_sel
    import bypass_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_idx_t src,
    input  dst_t     exmem,
    input  dst_t     memwb,
    output opsel_e   sel
);

    logic hit_alu;
    logic hit_wb;

    assign hit_alu = produces(exmem, src);
    assign hit_wb  = produces(memwb, src);

    // younger producer first
    always_comb begin
        if (hit_alu) begin
            sel = OPSEL_ALU;
        end else if (hit_wb) begin
            sel = OPSEL_WB;
        end else begin
            sel = OPSEL_RF;
        end
    end

    // R6: reading r0 always comes from the register file
    a_r6_zero_from_rf: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (sel == OPSEL_RF));

    // R5: only the three legal encodings appear
    a_r5_legal_select: assert property (@(posedge clk) disable iff (rst)
        (sel == OPSEL_RF) || (sel == OPSEL_WB) || (sel == OPSEL_ALU));

    // R9: a load two stages ahead reaches execute on the write-back path
    a_r9_load_via_wb: assert property (@(posedge clk) disable iff (rst)
        (memwb.is_load && memwb.reg_we && memwb.rd == src && src != '0 &&
         !(exmem.reg_we && exmem.rd == src)) |-> (sel == OPSEL_WB));

endmodule

// File: rtl/bypass_load_use.sv
module bypass_load_use
    import bypass_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  reg_idx_t [NUM_SRC-1:0]  id_src,
    input  slot_t                   idex,
    output logic                    stall
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = produces(to_dst(idex), id_src[g]);
    end

    assign stall = idex.is_load && (|hit);

    // R7: one cycle only, since the bubble that follows is never a load
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R6: a load to r0 never stalls
    a_r6_zero_no_stall: assert property (@(posedge clk) disable iff (rst)
        stall |-> (idex.rd != '0));

endmodule

// File: rtl/bypass_interlock.sv
module bypass_interlock
    import bypass_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic [4:0] id_rd,
    input  logic       id_reg_we,
    input  logic       id_mem_we,
    input  logic       id_is_load,
    output logic [1:0] fwd_a_sel,
    output logic [1:0] fwd_b_sel,
    output logic       stall,
    output logic [4:0] ex_rd,
    output logic       ex_reg_we,
    output logic       ex_mem_we,
    output logic       ex_is_load,
    output logic       ex_bubble
);

    slot_t                  id_slot;
    slot_t                  idex_q;
    dst_t                   exmem_q;
    dst_t                   memwb_q;
    reg_idx_t [NUM_SRC-1:0] id_src;
    reg_idx_t [NUM_SRC-1:0] ex_src;
    opsel_e   [NUM_SRC-1:0] sel;
    logic                   stall_w;

    always_comb begin
        id_slot         = SLOT_EMPTY;
        id_slot.rs1     = id_rs1;
        id_slot.rs2     = id_rs2;
        id_slot.rd      = id_rd;
        id_slot.reg_we  = id_reg_we;
        id_slot.mem_we  = id_mem_we;
        id_slot.is_load = id_is_load;
    end

    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;
    assign ex_src[0] = idex_q.rs1;
    assign ex_src[1] = idex_q.rs2;

    bypass_stage_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .insert_bubble (stall_w),
        .id_slot       (id_slot),
        .idex_q        (idex_q),
        .exmem_q       (exmem_q),
        .memwb_q       (memwb_q)
    );

    bypass_load_use u_lu (
        .clk    (clk),
        .rst    (rst),
        .id_src (id_src),
        .idex   (idex_q),
        .stall  (stall_w)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        bypass_operand_sel u_sel (
            .clk   (clk),
            .rst   (rst),
            .src   (ex_src[g]),
            .exmem (exmem_q),
            .memwb (memwb_q),
            .sel   (sel[g])
        );
    end

    assign fwd_a_sel  = sel[0];
    assign fwd_b_sel  = sel[1];
    assign stall      = stall_w;
    assign ex_rd      = idex_q.rd;
    assign ex_reg_we  = idex_q.reg_we;
    assign ex_mem_we  = idex_q.mem_we;
    assign ex_is_load = idex_q.is_load;
    assign ex_bubble  = idex_q.bubble;

    // R7: the interlock keeps a load from ever being bypassed off the ALU path
    a_r7_no_early_load: assert property (@(posedge clk) disable iff (rst)
        (exmem_q.is_load && exmem_q.reg_we && exmem_q.rd != '0) |->
        (exmem_q.rd != idex_q.rs1 && exmem_q.rd != idex_q.rs2));

    // R2: an ALU-path select implies a writing producer one stage ahead
    a_r2_alu_has_producer: assert property (@(posedge clk) disable iff (rst)
        (fwd_a_sel == 2'b10 || fwd_b_sel == 2'b10) |-> exmem_q.reg_we);

endmodule

// File: tb/bypass_interlock_tb_top.sv
module bypass_interlock_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] id_rs1, id_rs2, id_rd;
    logic       id_reg_we, id_mem_we, id_is_load;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       stall;
    logic [4:0] ex_rd;
    logic       ex_reg_we, ex_mem_we, ex_is_load, ex_bubble;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #10 clk = ~clk;

    bypass_interlock dut_i (
        .clk(clk), .rst(rst),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
        .id_reg_we(id_reg_we), .id_mem_we(id_mem_we), .id_is_load(id_is_load),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .stall(stall),
        .ex_rd(ex_rd), .ex_reg_we(ex_reg_we), .ex_mem_we(ex_mem_we),
        .ex_is_load(ex_is_load), .ex_bubble(ex_bubble)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one decode instruction for one cycle; outputs settle 5 ns later
    task automatic put(int rs1, int rs2, int rd, bit we, bit mwe, bit ld);
        @(negedge clk);
        id_rs1 = 5'(rs1); id_rs2 = 5'(rs2); id_rd = 5'(rd);
        id_reg_we = we; id_mem_we = mwe; id_is_load = ld;
        #5;
    endtask

    task automatic nop();
        put(0, 0, 0, 0, 0, 0);
    endtask

    task automatic flush();
        repeat (3) nop();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        nop(); nop();
        chk("R1 fwd_a", fwd_a_sel, 0);
        chk("R1 fwd_b", fwd_b_sel, 0);
        chk("R1 stall", stall, 0);
        chk("R1 ex_reg_we", ex_reg_we, 0);
        chk("R1 ex_mem_we", ex_mem_we, 0);
        chk("R1 ex_is_load", ex_is_load, 0);
        chk("R1 ex_bubble", ex_bubble, 0);
        rst = 1'b0;
    endtask

    task automatic t_alu_adjacent();
        flush();
        put(2, 3, 1, 1, 0, 0);            // add r1
        put(1, 3, 4, 1, 0, 0);            // sub reads r1
        chk("R2 no stall", stall, 0);
        nop();
        chk("R2 fwd_a alu", fwd_a_sel, 2);
        chk("R5 fwd_b rf", fwd_b_sel, 0);
    endtask

    task automatic t_wb_distance();
        flush();
        put(2, 3, 5, 1, 0, 0);            // add r5
        nop();
        put(8, 5, 9, 1, 0, 0);            // or reads r5 on b
        nop();
        chk("R3 fwd_b wb", fwd_b_sel, 1);
        chk("R5 fwd_a rf", fwd_a_sel, 0);
    endtask

    task automatic t_priority();
        flush();
        put(2, 3, 7, 1, 0, 0);            // add r7
        put(2, 3, 7, 1, 0, 0);            // sub r7
        put(7, 7, 10, 1, 0, 0);           // and r7,r7
        nop();
        chk("R4 fwd_a younger", fwd_a_sel, 2);
        chk("R4 fwd_b younger", fwd_b_sel, 2);
    endtask

    task automatic t_load_use_store();
        flush();
        put(2, 0, 4, 1, 0, 1);            // lw r4
        put(9, 4, 0, 0, 1, 0);            // sw reads r4
        chk("R7 stall raised", stall, 1);
        put(9, 4, 0, 0, 1, 0);            // held in decode
        chk("R7 stall one cycle", stall, 0);
        chk("R8 ex_bubble", ex_bubble, 1);
        chk("R8 bubble reg_we", ex_reg_we, 0);
        chk("R8 bubble mem_we", ex_mem_we, 0);
        chk("R8 bubble load", ex_is_load, 0);
        nop();
        chk("R8 held store in ex", ex_mem_we, 1);
        chk("R8 bubble gone", ex_bubble, 0);
        chk("R3 load via wb", fwd_b_sel, 1);
        chk("R5 other operand rf", fwd_a_sel, 0);
    endtask

    task automatic t_overlap();
        flush();
        put(2, 0, 3, 1, 0, 0);            // add r3
        put(3, 0, 4, 1, 0, 1);            // lw r4 from r3
        put(4, 6, 8, 1, 0, 0);            // add reads r4 on a
        chk("R7 stall overlap", stall, 1);
        chk("R2 load addr bypass", fwd_a_sel, 2);
        put(4, 6, 8, 1, 0, 0);
        chk("R7 released", stall, 0);
        chk("R8 bubble overlap", ex_bubble, 1);
        nop();
        chk("R3 loaded value", fwd_a_sel, 1);
        chk("R8 consumer rd", ex_rd, 8);
    endtask

    task automatic t_load_gap();
        flush();
        put(2, 0, 6, 1, 0, 1);            // lw r6
        nop();
        put(6, 1, 11, 1, 0, 0);           // add reads r6
        chk("R9 no stall", stall, 0);
        nop();
        chk("R9 fwd_a wb", fwd_a_sel, 1);
    endtask

    task automatic t_zero_reg();
        flush();
        put(2, 3, 0, 1, 0, 0);            // add r0
        put(0, 0, 4, 1, 0, 0);
        nop();
        chk("R6 fwd_a r0", fwd_a_sel, 0);
        chk("R6 fwd_b r0", fwd_b_sel, 0);
        flush();
        put(2, 0, 0, 1, 0, 1);            // lw r0
        put(0, 0, 5, 1, 0, 0);
        chk("R6 no stall r0", stall, 0);
    endtask

    task automatic t_no_write();
        flush();
        put(2, 11, 11, 0, 1, 0);          // store with rd field 11
        put(11, 11, 12, 1, 0, 0);
        nop();
        chk("R10 fwd_a none", fwd_a_sel, 0);
        chk("R10 fwd_b none", fwd_b_sel, 0);
        flush();
        put(2, 0, 13, 0, 0, 1);           // load flag without write enable
        put(13, 0, 14, 1, 0, 0);
        chk("R10 no stall", stall, 0);
        flush();
        put(2, 0, 12, 1, 0, 1);           // lw r12
        put(1, 2, 14, 1, 0, 0);           // unrelated
        chk("R7 unrelated no stall", stall, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        id_rs1 = '0; id_rs2 = '0; id_rd = '0;
        id_reg_we = 0; id_mem_we = 0; id_is_load = 0;
        t_reset();
        t_alu_adjacent();
        t_wb_distance();
        t_priority();
        t_load_use_store();
        t_overlap();
        t_load_gap();
        t_zero_reg();
        t_no_write();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule